// File: doc/BRIEF.md
# Interrupt Status and Soft-Reset Controller

This block gathers event pulses from a stream decoder into sticky interrupt status bits and drives one level interrupt towards the processor. Events are sorted into groups: one top group, one receiver group and one group for each channel. Every group has four word registers: a read-only status, an enable mask, a staged-clear register and a staged-set register. Writes to the staged registers change nothing visible in the status. A single command register then commits the staged clears, the staged sets, or both, across every group in the same cycle. An interrupt handler therefore reads each status, writes that value back to the matching staged-clear register, and finally issues one clear command.

A reset-strobe register starts a soft reset of selected sub-domains. The selected domain lines are held for a fixed number of cycles. Completion is reported as bit 0 of the top group status, so it travels the same masked interrupt path as any other event. Strobe bit 0 selects the register file itself. A strobe value with bit 0 low, such as 0x1E, resets the functional domains and keeps all register contents.

Top module: `irq_rst_ctrl`

## Requirements
- R1: Group g (0 = top, 1 = receiver, 2+i = channel i) has its base at byte address 0x10*(g+1). Status, mask, staged-clear and staged-set sit at base+0x0, +0x4, +0x8 and +0xC. The reset strobe is at 0x04 and the command register at 0x08. Reads of all other addresses return 0, and bits at or above the group width read 0. Writes to a status address have no effect.
- R2: An event input pulse sets its status bit on the next clock edge, and the bit stays set until a committed clear removes it.
- R3: Writing a staged-clear or staged-set register replaces its content, reads back that value, and leaves the status unchanged.
- R4: A write to the command register with data bit 0 set applies every group's staged clears. Data bit 4 set applies every group's staged sets. Each staged register is zeroed when its own command bit commits, and is kept otherwise.
- R5: An event in the same cycle as a committed clear of that bit leaves the bit set. A bit both staged-set and staged-clear in one commit ends up set.
- R6: `irq_o` is high exactly one cycle after any group has a status bit set whose mask bit is also set.
- R7: A nonzero strobe write drives that value on `rst_dom_o` for exactly RST_CYCLES cycles, starting on the edge of the write.
- R8: On the edge where `rst_dom_o` returns to zero, top status bit 0 becomes set.
- R9: A strobe write while a reset is running, or a strobe write of zero, is ignored. A read of the strobe address returns `rst_dom_o`.
- R10: A strobe write with bit 0 set clears every status, mask and staged register on its edge. A strobe with bit 0 clear keeps them.
- R11: After the asynchronous reset, all registers read 0, `irq_o` is low and `rst_dom_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address for reads and writes |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Combinational read data for `reg_addr` |
| ev_top | input | GW | Event pulses of the top group |
| ev_rx | input | GW | Event pulses of the receiver group |
| ev_ch | input | N_CH*GW | Event pulses of the channel groups, channel 0 in the low bits |
| irq_o | output | 1 | Registered level interrupt |
| rst_dom_o | output | SW | Active soft-reset domain selects |

## Verification
The bench targets the cycle where an event and a clear commit of the same bit coincide. If that case is handled wrongly, the bit is lost and its interrupt is never raised. It also checks that a commit applies only the staged register named by its command bit. A design that zeroed both staged registers would silently drop pending sets. The reset window is counted to the cycle, and strobes issued while a reset is running must be ignored. A strobe with bit 0 low must keep the masks, while one with bit 0 high must clear them. The bench also confirms that a completed reset is still reported after such a clear. Finally, the interrupt is sampled once before and once after its register stage, so an unregistered or late output is caught.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int OFS_STROBE  = 'h04;
  localparam int OFS_CMD     = 'h08;
  localparam int CMD_CLR_POS = 0;
  localparam int CMD_SET_POS = 4;

  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_MASK   = 2'd1,
    SLOT_CLR    = 2'd2,
    SLOT_SET    = 2'd3
  } slot_e;

  // byte base of interrupt group g
  function automatic int grp_base(input int g);
    return (g + 1) * 16;
  endfunction
endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter int AW = 12,
  parameter int NG = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  output logic [NG-1:0] grp_sel,
  output slot_e         slot,
  output logic [NG-1:0] wr_mask,
  output logic [NG-1:0] wr_clr,
  output logic [NG-1:0] wr_set,
  output logic          strobe_hit,
  output logic          wr_strobe,
  output logic          wr_cmd
);
  logic cmd_hit;

  assign slot       = slot_e'(addr[3:2]);
  assign strobe_hit = (int'(addr) == OFS_STROBE);
  assign cmd_hit    = (int'(addr) == OFS_CMD);
  assign wr_strobe  = wr_en && strobe_hit;
  assign wr_cmd     = wr_en && cmd_hit;

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      grp_sel[g] = (int'({addr[AW-1:4], 4'b0000}) == grp_base(g));
      wr_mask[g] = wr_en && grp_sel[g] && (slot == SLOT_MASK);
      wr_clr[g]  = wr_en && grp_sel[g] && (slot == SLOT_CLR);
      wr_set[g]  = wr_en && grp_sel[g] && (slot == SLOT_SET);
    end
  end
endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          wr_mask,
  input  logic          wr_clr,
  input  logic          wr_set,
  input  logic [GW-1:0] wdata,
  input  logic          do_clr,
  input  logic          do_set,
  input  logic [GW-1:0] ev,
  output logic [GW-1:0] status,
  output logic [GW-1:0] mask,
  output logic [GW-1:0] stg_clr,
  output logic [GW-1:0] stg_set,
  output logic          pend
);
  // commit order: clears first, then sets, events always last (they win)
  function automatic logic [GW-1:0] next_status(
    input logic [GW-1:0] cur, input logic [GW-1:0] clr,
    input logic [GW-1:0] set, input logic [GW-1:0] evs,
    input logic apply_clr, input logic apply_set);
    logic [GW-1:0] r;
    r = cur;
    if (apply_clr) r = r & ~clr;
    if (apply_set) r = r | set;
    return r | evs;
  endfunction

  logic [GW-1:0] status_nxt;
  assign status_nxt = next_status(status, stg_clr, stg_set, ev, do_clr, do_set);
  assign pend       = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      mask    <= '0;
      stg_clr <= '0;
      stg_set <= '0;
    end else if (wipe) begin
      status  <= '0;
      mask    <= '0;
      stg_clr <= '0;
      stg_set <= '0;
    end else begin
      status <= status_nxt;
      if (wr_mask) mask <= wdata;
      if (wr_clr)      stg_clr <= wdata;
      else if (do_clr) stg_clr <= '0;
      if (wr_set)      stg_set <= wdata;
      else if (do_set) stg_set <= '0;
    end
  end
endmodule

// File: rtl/irqc_rstseq.sv
module irqc_rstseq #(
  parameter int SW         = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] sel,
  output logic [SW-1:0] dom,
  output logic          active,
  output logic          done,
  output logic          wipe
);
  localparam int            CW   = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = start && (sel != '0) && !active;
  assign wipe   = accept && sel[0];
  assign done   = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom    <= '0;
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      dom    <= sel;
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (done) begin
        dom    <= '0;
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_rst_ctrl.sv
module irq_rst_ctrl
  import irqc_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int GW         = 16,
  parameter int N_CH       = 2,
  parameter int SW         = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [GW-1:0]    ev_top,
  input  logic [GW-1:0]    ev_rx,
  input  logic [N_CH*GW-1:0] ev_ch,
  output logic             irq_o,
  output logic [SW-1:0]    rst_dom_o
);
  localparam int NG = 2 + N_CH;

  logic [NG-1:0]    grp_sel, wr_mask, wr_clr, wr_set, pend;
  slot_e            slot;
  logic             strobe_hit, wr_strobe, wr_cmd;
  logic             cmd_clr, cmd_set;
  logic             seq_active, seq_done, rf_wipe;
  logic [NG*GW-1:0] status_flat, mask_flat, stg_clr_flat, stg_set_flat, ev_all_flat;

  assign cmd_clr = wr_cmd && wr_data[CMD_CLR_POS];
  assign cmd_set = wr_cmd && wr_data[CMD_SET_POS];

  irqc_regdec #(.AW(AW), .NG(NG)) u_dec (
    .addr(reg_addr), .wr_en(wr_en), .grp_sel(grp_sel), .slot(slot),
    .wr_mask(wr_mask), .wr_clr(wr_clr), .wr_set(wr_set),
    .strobe_hit(strobe_hit), .wr_strobe(wr_strobe), .wr_cmd(wr_cmd)
  );

  irqc_rstseq #(.SW(SW), .RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_strobe), .sel(wr_data[SW-1:0]),
    .dom(rst_dom_o), .active(seq_active), .done(seq_done), .wipe(rf_wipe)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GW-1:0] ev_g;
    if (g == 0) begin : g_top
      assign ev_g = ev_top | GW'(seq_done);
    end else if (g == 1) begin : g_rx
      assign ev_g = ev_rx;
    end else begin : g_ch
      assign ev_g = ev_ch[(g-2)*GW +: GW];
    end
    assign ev_all_flat[g*GW +: GW] = ev_g;

    irqc_group #(.GW(GW)) u_grp (
      .clk(clk), .rst_n(rst_n), .wipe(rf_wipe),
      .wr_mask(wr_mask[g]), .wr_clr(wr_clr[g]), .wr_set(wr_set[g]),
      .wdata(wr_data[GW-1:0]), .do_clr(cmd_clr), .do_set(cmd_set), .ev(ev_g),
      .status(status_flat[g*GW +: GW]), .mask(mask_flat[g*GW +: GW]),
      .stg_clr(stg_clr_flat[g*GW +: GW]), .stg_set(stg_set_flat[g*GW +: GW]),
      .pend(pend[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (strobe_hit) rd_data = DW'(rst_dom_o);
    for (int g = 0; g < NG; g++) begin
      if (grp_sel[g]) begin
        case (slot)
          SLOT_STATUS: rd_data = DW'(status_flat[g*GW +: GW]);
          SLOT_MASK:   rd_data = DW'(mask_flat[g*GW +: GW]);
          SLOT_CLR:    rd_data = DW'(stg_clr_flat[g*GW +: GW]);
          default:     rd_data = DW'(stg_set_flat[g*GW +: GW]);
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |pend;
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NG         = 4,
  parameter int GW         = 16,
  parameter int SW         = 5,
  parameter int RST_CYCLES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NG*GW-1:0] status_flat,
  input logic [NG*GW-1:0] mask_flat,
  input logic [NG*GW-1:0] stg_clr_flat,
  input logic [NG*GW-1:0] stg_set_flat,
  input logic [NG*GW-1:0] ev_all_flat,
  input logic             cmd_clr,
  input logic             cmd_set,
  input logic             rf_wipe,
  input logic             seq_active,
  input logic             seq_done,
  input logic             wr_strobe,
  input logic             irq_o,
  input logic [SW-1:0]    rst_dom_o
);
  int act_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_cnt <= 0;
    else if (seq_active) act_cnt <= act_cnt + 1;
    else                 act_cnt <= 0;
  end

  // R2
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_wipe |=> ((status_flat & $past(ev_all_flat)) == $past(ev_all_flat)));
  // R3
  no_silent_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_clr && !rf_wipe) |=> (($past(status_flat) & ~status_flat) == '0));
  // R3
  no_silent_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_set |=> ((status_flat & ~$past(status_flat) & ~$past(ev_all_flat)) == '0));
  // R4
  clr_stage_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (stg_clr_flat == '0));
  // R4
  set_stage_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> (stg_set_flat == '0));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> ((status_flat & $past(stg_set_flat)) == $past(stg_set_flat)));
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_flat & mask_flat))));
  // R7
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_active) |-> (act_cnt == RST_CYCLES));
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!seq_active && status_flat[0]));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !seq_done && wr_strobe) |=> $stable(rst_dom_o));
  // R10
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wipe |=> (status_flat == '0 && mask_flat == '0));
endmodule

bind irq_rst_ctrl irqc_chk #(.NG(NG), .GW(GW), .SW(SW), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_flat(status_flat), .mask_flat(mask_flat),
  .stg_clr_flat(stg_clr_flat), .stg_set_flat(stg_set_flat), .ev_all_flat(ev_all_flat),
  .cmd_clr(cmd_clr), .cmd_set(cmd_set), .rf_wipe(rf_wipe), .seq_active(seq_active),
  .seq_done(seq_done), .wr_strobe(wr_strobe), .irq_o(irq_o), .rst_dom_o(rst_dom_o)
);

// File: tb/irq_rst_ctrl_bench.sv
module irq_rst_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, DW = 32, GW = 16, N_CH = 2, SW = 5, RST_CYCLES = 16;

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_E = 2'd2, OP_I = 2'd3;
  localparam int NV = 48;
  // {op, addr, data}; for OP_R data is the expected read, for OP_I bit 0 is the expected irq
  localparam logic [45:0] VEC [NV] = '{
    {OP_E, 12'h030, 32'h0000_0005}, // R2 ch0 events
    {OP_R, 12'h030, 32'h0000_0005}, // R2
    {OP_I, 12'h000, 32'h0},         // R6 masked off
    {OP_W, 12'h034, 32'h0000_0004},
    {OP_I, 12'h000, 32'h1},         // R6
    {OP_W, 12'h038, 32'h0000_0004},
    {OP_R, 12'h038, 32'h0000_0004}, // R3 staged readable
    {OP_R, 12'h030, 32'h0000_0005}, // R3 not applied yet
    {OP_W, 12'h008, 32'h0000_0001},
    {OP_R, 12'h030, 32'h0000_0001}, // R4 clear commit
    {OP_R, 12'h038, 32'h0},         // R4 stage zeroed
    {OP_I, 12'h000, 32'h0},         // R6
    {OP_W, 12'h04C, 32'h0000_8000},
    {OP_R, 12'h040, 32'h0},         // R3
    {OP_W, 12'h008, 32'h0000_0010},
    {OP_R, 12'h040, 32'h0000_8000}, // R4 set commit
    {OP_R, 12'h04C, 32'h0},         // R4
    {OP_W, 12'h044, 32'h0000_8000},
    {OP_I, 12'h000, 32'h1},         // R6
    {OP_W, 12'h048, 32'h0000_8000},
    {OP_W, 12'h008, 32'h0000_0001},
    {OP_R, 12'h040, 32'h0},         // R4
    {OP_I, 12'h000, 32'h0},         // R6
    {OP_W, 12'h02C, 32'h0000_0010},
    {OP_W, 12'h008, 32'h0000_0001},
    {OP_R, 12'h02C, 32'h0000_0010}, // R4 set stage kept by clear-only commit
    {OP_R, 12'h020, 32'h0},         // R4
    {OP_W, 12'h008, 32'h0000_0010},
    {OP_R, 12'h020, 32'h0000_0010}, // R4
    {OP_W, 12'h028, 32'h0000_0010},
    {OP_W, 12'h02C, 32'h0000_0010},
    {OP_W, 12'h008, 32'h0000_0011},
    {OP_R, 12'h020, 32'h0000_0010}, // R5 set beats clear
    {OP_R, 12'h028, 32'h0},         // R4
    {OP_W, 12'h028, 32'h0000_0010},
    {OP_W, 12'h008, 32'h0000_0001},
    {OP_R, 12'h020, 32'h0},         // R4
    {OP_W, 12'h024, 32'hFFFF_FFFF},
    {OP_R, 12'h024, 32'h0000_FFFF}, // R1 width
    {OP_W, 12'h024, 32'h0},
    {OP_W, 12'h030, 32'h0000_FFFF},
    {OP_R, 12'h030, 32'h0000_0001}, // R1 status read-only
    {OP_R, 12'h100, 32'h0},         // R1 unmapped
    {OP_R, 12'h050, 32'h0},         // R1 past last group
    {OP_W, 12'h038, 32'h0000_0003},
    {OP_W, 12'h038, 32'h0000_0002},
    {OP_R, 12'h038, 32'h0000_0002}, // R3 replace
    {OP_W, 12'h038, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [GW-1:0] ev_top = '0, ev_rx = '0;
  logic [N_CH*GW-1:0] ev_ch = '0;
  logic irq_o;
  logic [SW-1:0] rst_dom_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_rst_ctrl #(.AW(AW), .DW(DW), .GW(GW), .N_CH(N_CH), .SW(SW), .RST_CYCLES(RST_CYCLES))
  u_irq_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .ev_top(ev_top), .ev_rx(ev_rx), .ev_ch(ev_ch),
    .irq_o(irq_o), .rst_dom_o(rst_dom_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    reg_addr = a;
    #1;
    check(rd_data === exp, req, rd_data, exp);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [GW-1:0] d);
    if (a == 12'h010) ev_top = d;
    else if (a == 12'h020) ev_rx = d;
    else ev_ch[(int'(a >> 4) - 3)*GW +: GW] = d;
    @(negedge clk);
    ev_top = '0; ev_rx = '0; ev_ch = '0;
  endtask

  task automatic irq_is(input logic exp, input string req);
    @(negedge clk);
    check(irq_o === exp, req, 32'(irq_o), 32'(exp));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(irq_o === 1'b0, "R11", 32'(irq_o), 0);
    check(rst_dom_o === '0, "R11", 32'(rst_dom_o), 0);
    rd(12'h010, 0, "R11");
    rd(12'h034, 0, "R11");
    rd(12'h004, 0, "R11");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [11:0] a; logic [31:0] d;
      {op, a, d} = VEC[i];
      case (op)
        OP_W: wr(a, d);
        OP_R: rd(a, d, $sformatf("R1-R5 vec%0d", i));
        OP_E: pulse(a, d[GW-1:0]);
        default: irq_is(d[0], $sformatf("R6 vec%0d", i));
      endcase
    end

    // R5 event beats a clear commit in the same cycle
    pulse(12'h020, 16'h0004);
    wr(12'h028, 32'h000C);
    ev_rx = 16'h0008; wr_en = 1'b1; reg_addr = 12'h008; wr_data = 32'h1;
    @(negedge clk);
    ev_rx = '0; wr_en = 1'b0;
    rd(12'h020, 32'h0008, "R5");
    wr(12'h028, 32'h0008);
    wr(12'h008, 32'h1);
    rd(12'h020, 32'h0, "R5");

    // R6 registered one cycle
    pulse(12'h020, 16'h0100);
    wr(12'h024, 32'h0100);
    check(irq_o === 1'b0, "R6 early", 32'(irq_o), 0);
    irq_is(1'b1, "R6");

    // R7 / R8 / R9 / R10 with register-keeping strobe
    wr(12'h004, 32'h1E);
    check(rst_dom_o === 5'h1E, "R7", 32'(rst_dom_o), 32'h1E);
    wr(12'h004, 32'h03);
    check(rst_dom_o === 5'h1E, "R9 busy", 32'(rst_dom_o), 32'h1E);
    rd(12'h004, 32'h1E, "R9 read");
    n = 3;
    while (rst_dom_o != '0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == RST_CYCLES + 1, "R7 length", 32'(n - 1), 32'(RST_CYCLES));
    rd(12'h010, 32'h1, "R8");
    rd(12'h024, 32'h0100, "R10 kept");
    rd(12'h020, 32'h0100, "R10 kept");
    wr(12'h014, 32'h1);
    wr(12'h018, 32'h1);
    wr(12'h008, 32'h1);
    rd(12'h010, 32'h0, "R4 top");

    // R9 zero strobe
    wr(12'h004, 32'h0);
    check(rst_dom_o === '0, "R9 zero", 32'(rst_dom_o), 0);
    repeat (20) @(negedge clk);
    rd(12'h010, 32'h0, "R9 zero");

    // R10 register-file wipe
    wr(12'h02C, 32'h0002);
    wr(12'h004, 32'h01);
    check(rst_dom_o === 5'h01, "R7", 32'(rst_dom_o), 1);
    rd(12'h020, 0, "R10");
    rd(12'h024, 0, "R10");
    rd(12'h02C, 0, "R10");
    rd(12'h014, 0, "R10");
    check(irq_o === 1'b0, "R10 irq", 32'(irq_o), 0);
    n = 0;
    while (rst_dom_o != '0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    rd(12'h010, 32'h1, "R8 after wipe");
    check(irq_o === 1'b0, "R6 masked done", 32'(irq_o), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule